// File: doc/BRIEF.md
# RAM Address and Data Scrambler

This block sits between a processor's memory port and a 32768-word, 32-bit RAM (128 KiB). It hides how stored values are laid out physically. The word index presented to the RAM is the processor's word index XORed with a secret address key. The word stored is the processor's data XORed with a secret data key and with the processor's full byte address. On a read the same mask is applied to the returned word, so software sees its original value and does not know the mapping exists. As a result, one value written to two different addresses ends up as two different words in the RAM.

Boot firmware loads the two keys through a small write-only register port. Both keys are zero after reset. The request side is a valid/ready stream. The block never applies back-pressure: `cpu_req_ready` is always high. A request is accepted in any cycle where `cpu_req_valid` is high, and it goes to the RAM in that same cycle. The RAM answers reads one cycle later. The read response has no ready signal, so the requester must take `cpu_rsp_rdata` in the cycle `cpu_rsp_valid` is high.

Top module: `ram_scrambler`

## Requirements
- R1: For an accepted request, `ram_addr` equals byte-address bits [16:2] XOR the 15-bit address key, in the same cycle. Address bits above 16 do not take part in the RAM index.
- R2: For an accepted write, `ram_wdata` equals `cpu_req_wdata` XOR the 32-bit data key XOR the full 32-bit `cpu_req_addr`, in the same cycle.
- R3: `ram_be` equals `cpu_req_wstrb` unchanged, where bit n enables byte lane n (bits 8n+7:8n). `ram_we` is high exactly when an accepted request has `cpu_req_we` high.
- R4: An accepted read produces `cpu_rsp_valid` high in the next cycle only. `cpu_rsp_rdata` then equals `ram_rdata` XOR the data key and address of that read.
- R5: During and after reset, `cpu_rsp_valid` is low and both keys are zero. `ram_addr` is then the plain word index, and write data is masked by the address alone.
- R6: A config write with `cfg_sel` = 0 loads `cfg_wdata[14:0]` into the address key. With `cfg_sel` = 1 it loads all 32 bits into the data key. The new key applies from the next cycle.
- R7: `cpu_req_ready` is always high. `ram_en` follows `cpu_req_valid`. Writes produce no response.
- R8: A word written and then read back at the same address returns the written value for any key pair. The same value written at two addresses is stored as two different RAM words.
- R9: A key change made in the same cycle as a read request does not alter that read's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Key register write strobe |
| cfg_sel | input | 1 | Key select: 0 address key, 1 data key |
| cfg_wdata | input | 32 | Key value |
| cpu_req_valid | input | 1 | Request valid |
| cpu_req_ready | output | 1 | Request ready (always high) |
| cpu_req_we | input | 1 | Request is a write |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Write data |
| cpu_req_wstrb | input | 4 | Byte lane strobes |
| cpu_rsp_valid | output | 1 | Read data valid |
| cpu_rsp_rdata | output | 32 | Unscrambled read data |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_be | output | 4 | RAM byte enables |
| ram_addr | output | 15 | Mapped RAM word index |
| ram_wdata | output | 32 | Scrambled write data |
| ram_rdata | input | 32 | RAM read data, one cycle after `ram_en` |

## Verification
The RAM-side address, data and enables are combinational from the request, so the bench checks them in the same cycle, half a period after it drives the request. The unscrambled read word arrives one clock after acceptance, and the bench's reference model holds its expected value for exactly one cycle before comparing it. A key write affects only requests from the following cycle on, so the model applies key updates after it has judged the current cycle's request. This is how it shows that a key change made in the same cycle as a read leaves that read's response unchanged.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic {
    KEY_SEL_ADDR = 1'b0,
    KEY_SEL_DATA = 1'b1
  } key_sel_e;
endpackage

// File: rtl/scr_key_regs.sv
module scr_key_regs #(
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [WORD_AW-1:0] addr_key,
  output logic [DATA_W-1:0]  data_key
);
  import scr_pkg::*;

  logic ld_addr;
  logic ld_data;

  assign ld_addr = cfg_we && (key_sel_e'(cfg_sel) == KEY_SEL_ADDR);
  assign ld_data = cfg_we && (key_sel_e'(cfg_sel) == KEY_SEL_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_key <= '0;
    end else if (ld_addr) begin
      addr_key <= cfg_wdata[WORD_AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_key <= '0;
    end else if (ld_data) begin
      data_key <= cfg_wdata;
    end
  end
endmodule

// File: rtl/scr_addr_map.sv
module scr_addr_map #(
  parameter int WORD_AW = 15
) (
  input  logic [WORD_AW-1:0] word_idx,
  input  logic [WORD_AW-1:0] addr_key,
  output logic [WORD_AW-1:0] phys_idx
);
  for (genvar b = 0; b < WORD_AW; b++) begin : g_bit
    assign phys_idx[b] = word_idx[b] ^ addr_key[b];
  end
endmodule

// File: rtl/scr_rsp_pipe.sv
module scr_rsp_pipe #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] mask_in,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      mask_q    <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) mask_q <= mask_in;
    end
  end

  assign rsp_rdata = ram_rdata ^ mask_q;
endmodule

// File: rtl/ram_scrambler.sv
module ram_scrambler #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int RAM_WORDS = 32768,
  localparam int WORD_AW  = $clog2(RAM_WORDS),
  localparam int LANES    = DATA_W / 8,
  localparam int BYTE_OFF = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               cpu_req_valid,
  output logic               cpu_req_ready,
  input  logic               cpu_req_we,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic [DATA_W-1:0]  cpu_req_wdata,
  input  logic [LANES-1:0]   cpu_req_wstrb,
  output logic               cpu_rsp_valid,
  output logic [DATA_W-1:0]  cpu_rsp_rdata,
  output logic               ram_en,
  output logic               ram_we,
  output logic [LANES-1:0]   ram_be,
  output logic [WORD_AW-1:0] ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic [DATA_W-1:0]  ram_rdata
);
  logic [WORD_AW-1:0] addr_key;
  logic [DATA_W-1:0]  data_key;
  logic [DATA_W-1:0]  data_mask;
  logic               fire;

  scr_key_regs #(.DATA_W(DATA_W), .WORD_AW(WORD_AW)) u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .addr_key (addr_key),
    .data_key (data_key)
  );

  scr_addr_map #(.WORD_AW(WORD_AW)) u_map (
    .word_idx(cpu_req_addr[BYTE_OFF +: WORD_AW]),
    .addr_key(addr_key),
    .phys_idx(ram_addr)
  );

  assign cpu_req_ready = 1'b1;
  assign fire          = cpu_req_valid && cpu_req_ready;
  assign data_mask     = data_key ^ DATA_W'(cpu_req_addr);

  assign ram_en    = fire;
  assign ram_we    = fire && cpu_req_we;
  assign ram_be    = cpu_req_wstrb;
  assign ram_wdata = cpu_req_wdata ^ data_mask;

  scr_rsp_pipe #(.DATA_W(DATA_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (fire && !cpu_req_we),
    .mask_in  (data_mask),
    .ram_rdata(ram_rdata),
    .rsp_valid(cpu_rsp_valid),
    .rsp_rdata(cpu_rsp_rdata)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int DATA_W   = 32,
  parameter int WORD_AW  = 15,
  parameter int LANES    = 4,
  parameter int BYTE_OFF = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic               cfg_sel,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic               cpu_req_valid,
  input logic               cpu_req_we,
  input logic [DATA_W-1:0]  cpu_req_addr,
  input logic [DATA_W-1:0]  cpu_req_wdata,
  input logic [LANES-1:0]   cpu_req_wstrb,
  input logic               cpu_rsp_valid,
  input logic [DATA_W-1:0]  cpu_rsp_rdata,
  input logic               ram_en,
  input logic               ram_we,
  input logic [LANES-1:0]   ram_be,
  input logic [WORD_AW-1:0] ram_addr,
  input logic [DATA_W-1:0]  ram_wdata,
  input logic [DATA_W-1:0]  ram_rdata,
  input logic [WORD_AW-1:0] addr_key,
  input logic [DATA_W-1:0]  data_key
);
  p_addr_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> ram_addr == (cpu_req_addr[BYTE_OFF +: WORD_AW] ^ addr_key));

  p_wdata_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_we) |-> ram_wdata == (cpu_req_wdata ^ data_key ^ cpu_req_addr));

  p_strobe_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (ram_be == cpu_req_wstrb && ram_we == cpu_req_we));

  p_rsp_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_we) |=> cpu_rsp_valid);

  p_rsp_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_we) |=>
      cpu_rsp_rdata == (ram_rdata ^ $past(data_key) ^ $past(cpu_req_addr)));

  p_addr_key_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> addr_key == $past(cfg_wdata[WORD_AW-1:0]));

  p_data_key_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> data_key == $past(cfg_wdata));

  p_no_stray_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_en && !ram_we) |=> !cpu_rsp_valid);

  p_enable_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid |-> ram_en);
endmodule

bind ram_scrambler scr_checker #(
  .DATA_W(DATA_W), .WORD_AW(WORD_AW), .LANES(LANES), .BYTE_OFF(BYTE_OFF)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_sel      (cfg_sel),
  .cfg_wdata    (cfg_wdata),
  .cpu_req_valid(cpu_req_valid),
  .cpu_req_we   (cpu_req_we),
  .cpu_req_addr (cpu_req_addr),
  .cpu_req_wdata(cpu_req_wdata),
  .cpu_req_wstrb(cpu_req_wstrb),
  .cpu_rsp_valid(cpu_rsp_valid),
  .cpu_rsp_rdata(cpu_rsp_rdata),
  .ram_en       (ram_en),
  .ram_we       (ram_we),
  .ram_be       (ram_be),
  .ram_addr     (ram_addr),
  .ram_wdata    (ram_wdata),
  .ram_rdata    (ram_rdata),
  .addr_key     (addr_key),
  .data_key     (data_key)
);

// File: tb/ram_scrambler_tb_top.sv
module ram_scrambler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_we = 1'b0;
  logic [31:0] cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic [3:0]  cpu_req_wstrb = '0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        ram_en;
  logic        ram_we;
  logic [3:0]  ram_be;
  logic [14:0] ram_addr;
  logic [31:0] ram_wdata;
  logic [31:0] ram_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ram_scrambler dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_req_wstrb(cpu_req_wstrb),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_be(ram_be),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // RAM array driven only by the DUT's RAM-side ports
  logic [31:0] bmem [int];
  always @(posedge clk) begin
    if (ram_en) begin
      logic [31:0] cur;
      cur = bmem.exists(int'(ram_addr)) ? bmem[int'(ram_addr)] : 32'h0;
      if (ram_we) begin
        for (int b = 0; b < 4; b++)
          if (ram_be[b]) cur[8*b +: 8] = ram_wdata[8*b +: 8];
        bmem[int'(ram_addr)] = cur;
      end else begin
        ram_rdata <= cur;
      end
    end
  end

  // Behavioural reference model, compared every clock at the falling edge
  logic [31:0] ref_mem [int];
  logic [14:0] ka = '0;
  logic [31:0] kd = '0;
  bit          exp_v = 1'b0;
  logic [31:0] exp_d = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(cpu_rsp_valid == 1'b0, "R5 no response in reset", 32'(cpu_rsp_valid), 32'h0);
      ka = '0; kd = '0; exp_v = 1'b0;
    end else if (!done) begin
      bit          nv;
      logic [31:0] nd;
      logic [14:0] w;
      logic [31:0] m;
      logic [31:0] cur;
      nv = 1'b0; nd = '0;
      chk(cpu_rsp_valid == exp_v, "R4/R7 response valid timing", 32'(cpu_rsp_valid), 32'(exp_v));
      if (exp_v)
        chk(cpu_rsp_rdata == exp_d, "R4 response data", cpu_rsp_rdata, exp_d);
      chk(cpu_req_ready == 1'b1, "R7 ready always high", 32'(cpu_req_ready), 32'h1);
      chk(ram_en == cpu_req_valid, "R7 ram_en follows valid", 32'(ram_en), 32'(cpu_req_valid));
      if (cpu_req_valid) begin
        w = cpu_req_addr[16:2] ^ ka;
        m = kd ^ cpu_req_addr;
        chk(ram_addr == w, "R1 mapped index", 32'(ram_addr), 32'(w));
        chk(ram_we == cpu_req_we && ram_be == cpu_req_wstrb, "R3 enables",
            {27'h0, ram_we, ram_be}, {27'h0, cpu_req_we, cpu_req_wstrb});
        cur = ref_mem.exists(int'(w)) ? ref_mem[int'(w)] : 32'h0;
        if (cpu_req_we) begin
          chk(ram_wdata == (cpu_req_wdata ^ m), "R2 scrambled data", ram_wdata,
              cpu_req_wdata ^ m);
          for (int b = 0; b < 4; b++)
            if (cpu_req_wstrb[b]) cur[8*b +: 8] = cpu_req_wdata[8*b +: 8] ^ m[8*b +: 8];
          ref_mem[int'(w)] = cur;
        end else begin
          nv = 1'b1;
          nd = cur ^ m;
        end
      end
      exp_v = nv;
      exp_d = nd;
      if (cfg_we) begin
        if (cfg_sel) kd = cfg_wdata;
        else         ka = cfg_wdata[14:0];
      end
    end
  end

  task automatic drive_req(input bit we, input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] s);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a;
    cpu_req_wdata = d; cpu_req_wstrb = s;
  endtask

  task automatic end_cycle();
    @(posedge clk); #1;
    cpu_req_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic set_key(input bit sel, input logic [31:0] v);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    end_cycle();
  endtask

  task automatic write_word(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    drive_req(1'b1, a, d, s);
    end_cycle();
  endtask

  task automatic read_expect(input logic [31:0] a, input logic [31:0] e, input string req);
    drive_req(1'b0, a, '0, '0);
    end_cycle();
    @(negedge clk);
    chk(cpu_rsp_valid && cpu_rsp_rdata == e, req, cpu_rsp_rdata, e);
    @(posedge clk); #1;
  endtask

  initial begin
    logic [31:0] s1;
    logic [31:0] s2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R5: zero keys after reset, index passes through, data masked by address only
    drive_req(1'b1, 32'h0000_0040, 32'hA5A5_0001, 4'hF);
    @(negedge clk);
    chk(ram_addr == 15'h0010, "R5 identity index", 32'(ram_addr), 32'h10);
    chk(ram_wdata == (32'hA5A5_0001 ^ 32'h40), "R5 address-only mask", ram_wdata,
        32'hA5A5_0041);
    end_cycle();
    read_expect(32'h0000_0040, 32'hA5A5_0001, "R5 round trip with zero keys");

    // R6: load keys, new address key used by the next request
    set_key(1'b0, 32'hFFFF_5A5A);
    set_key(1'b1, 32'hDEAD_BEEF);
    drive_req(1'b1, 32'h0000_0100, 32'h1234_5678, 4'hF);
    @(negedge clk);
    chk(ram_addr == (15'h0040 ^ 15'h5A5A), "R6 address key loaded", 32'(ram_addr),
        32'(15'h0040 ^ 15'h5A5A));
    s1 = ram_wdata;
    chk(s1 == (32'h1234_5678 ^ 32'hDEAD_BEEF ^ 32'h100), "R6 data key loaded", s1,
        32'h1234_5678 ^ 32'hDEAD_BEEF ^ 32'h100);
    end_cycle();

    // R8: same value at a second address is stored differently
    drive_req(1'b1, 32'h0000_0200, 32'h1234_5678, 4'hF);
    @(negedge clk);
    s2 = ram_wdata;
    chk(s1 != s2, "R8 distinct stored words", s2, s1);
    end_cycle();
    read_expect(32'h0000_0100, 32'h1234_5678, "R8 round trip A");
    read_expect(32'h0000_0200, 32'h1234_5678, "R8 round trip B");

    // R3: single lane 1 write leaves other lanes intact
    write_word(32'h0000_0100, 32'hFFFF_FFFF, 4'b0010);
    read_expect(32'h0000_0100, 32'h1234_FF78, "R3 partial strobe");

    // R9: data key changes in the same cycle as a read request
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'h0BAD_F00D;
    drive_req(1'b0, 32'h0000_0200, '0, '0);
    end_cycle();
    @(negedge clk);
    chk(cpu_rsp_valid && cpu_rsp_rdata == 32'h1234_5678, "R9 key change ignored by read",
        cpu_rsp_rdata, 32'h1234_5678);
    @(posedge clk); #1;

    // R1: address bits above 16 do not move the RAM index
    drive_req(1'b0, 32'h0002_0100, '0, '0);
    @(negedge clk);
    chk(ram_addr == (15'h0040 ^ 15'h5A5A), "R1 upper bits ignored", 32'(ram_addr),
        32'(15'h0040 ^ 15'h5A5A));
    end_cycle();
    @(posedge clk); #1;

    // Back-to-back traffic with random keys and random strobes
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 16) == 0) begin
        cfg_we = 1'b1; cfg_sel = 1'($urandom); cfg_wdata = $urandom;
      end else begin
        cfg_we = 1'b0;
      end
      if (($urandom % 4) != 0)
        drive_req(1'($urandom), {$urandom} & 32'h0000_00FC | (32'($urandom % 2) << 20),
                  $urandom, 4'($urandom));
      else
        cpu_req_valid = 1'b0;
      @(posedge clk); #1;
    end
    cpu_req_valid = 1'b0; cfg_we = 1'b0;
    repeat (3) @(posedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule